// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides a fast input clock into a slower output whose low and high phases are set independently by two 4-bit counts. Each phase lasts one cycle more than its count, so the full period is the sum of both counts plus two input cycles. A small two-register write port holds the ratio and control settings: bypass, whether the shared SYNC line is obeyed, a static forced level, the level the output starts in, and a delay in input cycles applied after SYNC is released.

Several channels share one SYNC line to align their edges. While SYNC is high, an obeying channel holds its output at the chosen start level with its counters cleared. Once SYNC drops, the channel waits the programmed offset and then runs its phases. Ratio changes made while the divider runs are deferred to the end of the current full period, so the output never shows a shortened pulse. The start level and offset are taken only while the channel is held.

Top module: `clkdiv_channel`

## Requirements
- R1: After reset the ratio register is 0, the offset, start and sync-ignore bits are 0, and the bypass bit equals parameter BYPASS_RST. With BYPASS_RST=0 the output is low during reset, and afterwards it divides by 2.
- R2: A write with cfg_sel=0 loads the low count M from cfg_wdata[3:0] and the high count N from cfg_wdata[7:4]. In steady running the output is high for N+1 input cycles and low for M+1, a period of M+N+2.
- R3: While the channel obeys SYNC (cfg_wdata[5] of register 1 is 0) and sync_i is high, the output sits at the start level and the counters are cleared.
- R4: Register 1 bits [3:0] hold the phase offset P. The first output change after release happens at the (P+K+1)-th rising edge at which sync_i is seen low, where K is the count of the start phase.
- R5: Register 1 bit 7 selects the start level: 0 starts in the low phase, 1 starts in the high phase.
- R6: With register 1 bit 5 set, sync_i has no effect and the output is the static level in register 1 bit 6.
- R7: With register 1 bit 4 set, the output follows clk_in directly, the counters are held, and the bit takes priority over the forced level.
- R8: A ratio write made while running takes effect only at the end of the current full period, when the output returns to the start level. The phase in progress and the phase after it keep their old lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Shared alignment line, active high, synchronous to clk_in |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 ratio, 1 control |
| cfg_wdata | input | 8 | Register write data |
| clk_out | output | 1 | Divided, bypassed or forced output |

## Verification
The assertions assume that sync_i and the register port are synchronous to clk_in and stable around its rising edge. They also assume that the offset and start level change only while the channel is held. The bench therefore drives every input on the falling edge. It writes offset and start settings only with SYNC high or with the channel bypassed. The one ratio write made while the divider runs is placed inside a low phase, which is the case the deferral rule covers. A behavioural reference model predicts clk_out after every rising edge. On top of that, explicit width measurements cover all four pairings of M and N at 0 and 15.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;
  localparam int CNT_W = 4;
  localparam int REG_W = 2 * CNT_W;
  // control register bit positions (phase occupies [CNT_W-1:0])
  localparam int BIT_BYP = CNT_W;
  localparam int BIT_IGN = CNT_W + 1;
  localparam int BIT_FRC = CNT_W + 2;
  localparam int BIT_STH = CNT_W + 3;

  typedef struct packed {
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] phase;
    logic             bypass;
    logic             ignore_sync;
    logic             force_lvl;
    logic             start_high;
  } chdiv_cfg_t;
endpackage

// File: rtl/chdiv_cfg_regs.sv
module chdiv_cfg_regs
  import chdiv_pkg::*;
#(
  parameter bit BYPASS_RST = 1'b0
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output chdiv_cfg_t       cfg
);
  localparam logic [REG_W-1:0] CTRL_RST = REG_W'(BYPASS_RST) << BIT_BYP;

  logic [REG_W-1:0] ratio_q;
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else if (wr_en) begin
      if (wr_sel) ctrl_q  <= wr_data;
      else        ratio_q <= wr_data;
    end
  end

  always_comb begin
    cfg.low_cnt     = ratio_q[CNT_W-1:0];
    cfg.high_cnt    = ratio_q[REG_W-1:CNT_W];
    cfg.phase       = ctrl_q[CNT_W-1:0];
    cfg.bypass      = ctrl_q[BIT_BYP];
    cfg.ignore_sync = ctrl_q[BIT_IGN];
    cfg.force_lvl   = ctrl_q[BIT_FRC];
    cfg.start_high  = ctrl_q[BIT_STH];
  end
endmodule

// File: rtl/chdiv_core.sv
module chdiv_core
  import chdiv_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       sync_i,
  input  chdiv_cfg_t cfg,
  output logic       hold,
  output logic       lvl
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wait_q;
  logic [CNT_W-1:0] low_sh;
  logic [CNT_W-1:0] high_sh;
  logic [CNT_W-1:0] cur_len;
  logic             start_sh;

  assign hold    = cfg.bypass | (~cfg.ignore_sync & sync_i);
  assign cur_len = lvl ? high_sh : low_sh;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      lvl      <= 1'b0;
      cnt_q    <= '0;
      wait_q   <= '0;
      low_sh   <= '0;
      high_sh  <= '0;
      start_sh <= 1'b0;
    end else if (hold) begin
      lvl      <= cfg.start_high;
      cnt_q    <= '0;
      wait_q   <= cfg.phase;
      low_sh   <= cfg.low_cnt;
      high_sh  <= cfg.high_cnt;
      start_sh <= cfg.start_high;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end else if (cnt_q == cur_len) begin
      lvl   <= ~lvl;
      cnt_q <= '0;
      // leaving the second phase closes a full period: adopt new ratio
      if (lvl != start_sh) begin
        low_sh  <= cfg.low_cnt;
        high_sh <= cfg.high_cnt;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chdiv_out_sel.sv
module chdiv_out_sel (
  input  logic clk_in,
  input  logic bypass,
  input  logic ignore_sync,
  input  logic force_lvl,
  input  logic div_lvl,
  output logic clk_out
);
  always_comb begin
    if (bypass)           clk_out = clk_in;
    else if (ignore_sync) clk_out = force_lvl;
    else                  clk_out = div_lvl;
  end
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import chdiv_pkg::*;
#(
  parameter bit BYPASS_RST = 1'b0
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             clk_out
);
  chdiv_cfg_t cfg;
  logic       core_hold;
  logic       div_lvl;

  chdiv_cfg_regs #(.BYPASS_RST(BYPASS_RST)) u_regs (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  chdiv_core u_core (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .cfg    (cfg),
    .hold   (core_hold),
    .lvl    (div_lvl)
  );

  chdiv_out_sel u_out (
    .clk_in      (clk_in),
    .bypass      (cfg.bypass),
    .ignore_sync (cfg.ignore_sync),
    .force_lvl   (cfg.force_lvl),
    .div_lvl     (div_lvl),
    .clk_out     (clk_out)
  );
endmodule

// File: rtl/chdiv_checker.sv
module chdiv_checker
  import chdiv_pkg::*;
(
  input logic             clk_in,
  input logic             rst_n,
  input logic             hold,
  input logic             ignore_sync,
  input logic             bypass,
  input logic             force_lvl,
  input logic             start_live,
  input logic [CNT_W-1:0] phase_live,
  input logic             div_lvl,
  input logic             clk_out
);
  logic [5:0]       run_len;
  logic [CNT_W:0]   rel_cnt;
  logic [CNT_W-1:0] cap_p;
  logic             lvl_d;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 6'd1;
      rel_cnt <= '0;
      cap_p   <= '0;
      lvl_d   <= 1'b0;
    end else begin
      lvl_d <= div_lvl;
      if (hold) begin
        run_len <= 6'd1;
        rel_cnt <= '0;
        cap_p   <= phase_live;
      end else begin
        if (div_lvl != lvl_d)     run_len <= 6'd1;
        else if (run_len != 6'h3f) run_len <= run_len + 1'b1;
        if (rel_cnt != '1)        rel_cnt <= rel_cnt + 1'b1;
      end
    end
  end

  // R3 / R5: a held channel shows the start level
  a_r3_hold_start: assert property (@(posedge clk_in) disable iff (!rst_n)
    hold |=> div_lvl == $past(start_live));

  // R4: no output change while the release offset is still running
  a_r4_offset_wait: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!hold && (rel_cnt < {1'b0, cap_p})) |=> $stable(div_lvl));

  // R2: no phase outlasts the longest count plus the longest offset
  a_r2_run_bound: assert property (@(posedge clk_in) disable iff (!rst_n)
    !hold |-> run_len <= 6'd34);

  // R6: with sync ignored and a steady force bit, the output is static
  a_r6_sync_no_effect: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ignore_sync && !bypass && $past(ignore_sync) && !$past(bypass)
     && $stable(force_lvl)) |-> $stable(clk_out));
endmodule

bind clkdiv_channel chdiv_checker u_chk (
  .clk_in      (clk_in),
  .rst_n       (rst_n),
  .hold        (core_hold),
  .ignore_sync (cfg.ignore_sync),
  .bypass      (cfg.bypass),
  .force_lvl   (cfg.force_lvl),
  .start_live  (cfg.start_high),
  .phase_live  (cfg.phase),
  .div_lvl     (div_lvl),
  .clk_out     (clk_out)
);

// File: tb/test_clkdiv_channel.sv
`timescale 1ns/1ps
module test_clkdiv_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       clk_out, clk_out_b;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  clkdiv_channel #(.BYPASS_RST(1'b0)) i_clkdiv_channel (
    .clk_in(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .clk_out(clk_out));

  clkdiv_channel #(.BYPASS_RST(1'b1)) i_clkdiv_channel_b (
    .clk_in(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_wr(1'b0),
    .cfg_sel(1'b0), .cfg_wdata(8'h00), .clk_out(clk_out_b));

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_ratio, m_ctrl;
  logic       m_lvl, m_start;
  int         m_lo, m_hi, m_rem;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ratio = 8'h00; m_ctrl = 8'h00;
      m_lvl = 1'b0; m_start = 1'b0; m_lo = 0; m_hi = 0; m_rem = 1;
    end else begin
      if (m_ctrl[4] || (!m_ctrl[5] && sync_i)) begin
        m_start = m_ctrl[7];
        m_lvl   = m_start;
        m_lo    = int'(m_ratio[3:0]);
        m_hi    = int'(m_ratio[7:4]);
        m_rem   = int'(m_ctrl[3:0]) + (m_start ? m_hi : m_lo) + 1;
      end else begin
        m_rem--;
        if (m_rem == 0) begin
          m_lvl = ~m_lvl;
          if (m_lvl == m_start) begin
            m_lo = int'(m_ratio[3:0]);
            m_hi = int'(m_ratio[7:4]);
          end
          m_rem = (m_lvl ? m_hi : m_lo) + 1;
        end
      end
      if (cfg_wr) begin
        if (cfg_sel) m_ctrl = cfg_wdata;
        else         m_ratio = cfg_wdata;
      end
    end
    #2;
    if (rst_n)
      check("R2 model", clk_out, m_ctrl[4] ? 1'b1 : (m_ctrl[5] ? m_ctrl[6] : m_lvl));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk); sync_i = 1'b1;
    repeat (3) @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic sample();
    @(posedge clk); #2;
  endtask

  task automatic wait_rise();
    logic prev;
    sample(); prev = clk_out;
    for (int k = 0; k < 200; k++) begin
      sample();
      if (!prev && clk_out) break;
      prev = clk_out;
    end
  endtask

  task automatic meas(output int hi, output int lo);
    wait_rise();
    hi = 1;
    for (int k = 0; k < 200 && clk_out; k++) begin sample(); if (clk_out) hi++; end
    lo = 1;
    for (int k = 0; k < 200 && !clk_out; k++) begin sample(); if (!clk_out) lo++; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int hi, lo, k;
    repeat (3) @(negedge clk);
    check("R1 reset low", clk_out, 1'b0);
    @(posedge clk); #2;
    check("R1 bypass reset default", clk_out_b, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    meas(hi, lo);
    check_int("R1 div2 high", hi, 1);
    check_int("R1 div2 low", lo, 1);

    // R2: corner ratios
    for (int m = 0; m <= 15; m += 15) begin
      for (int n = 0; n <= 15; n += 15) begin
        wr(1'b0, {4'(n), 4'(m)});
        sync_pulse();
        meas(hi, lo);
        check_int("R2 high width", hi, n + 1);
        check_int("R2 low width", lo, m + 1);
        check_int("R2 period", hi + lo, m + n + 2);
      end
    end

    // R3 / R5: held at start-high level
    @(negedge clk); sync_i = 1'b1;
    wr(1'b0, 8'h32);
    wr(1'b1, 8'h85);               // start high, offset 5
    for (int i = 0; i < 6; i++) begin
      sample(); check("R3 held at start level", clk_out, 1'b1);
    end
    // R4: first change at edge P+N+1 = 9
    @(negedge clk); sync_i = 1'b0;
    k = 0;
    do begin sample(); k++; end while (clk_out && k < 100);
    check_int("R4 offset then high phase", k, 9);

    // R5: start low, offset 3, M=2 -> change at edge 6
    @(negedge clk); sync_i = 1'b1;
    wr(1'b1, 8'h03);
    @(negedge clk); sync_i = 1'b0;
    k = 0;
    do begin sample(); k++; end while (!clk_out && k < 100);
    check_int("R5 start low first change", k, 6);

    // R8: ratio change during a low phase
    @(negedge clk); sync_i = 1'b1;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h33);
    @(negedge clk); sync_i = 1'b0;
    wait_rise();
    for (int i = 0; i < 20 && clk_out; i++) sample();   // now in low phase
    wr(1'b0, 8'h00);
    meas(hi, lo);
    check_int("R8 old high kept", hi, 4);
    check_int("R8 new low applied", lo, 1);

    // R6: ignore sync, forced level
    wr(1'b1, 8'h60);
    @(negedge clk); sync_i = 1'b1;
    for (int i = 0; i < 4; i++) begin sample(); check("R6 forced high", clk_out, 1'b1); end
    @(negedge clk); sync_i = 1'b0;
    sample(); check("R6 sync ignored", clk_out, 1'b1);
    wr(1'b1, 8'h20);
    for (int i = 0; i < 4; i++) begin sample(); check("R6 forced low", clk_out, 1'b0); end

    // R7: bypass follows clk_in, priority over force
    wr(1'b1, 8'h70);
    for (int i = 0; i < 4; i++) begin
      sample(); check("R7 bypass high", clk_out, 1'b1);
      @(negedge clk); #2; check("R7 bypass low", clk_out, 1'b0);
    end

    // resume dividing after bypass cleared
    wr(1'b0, 8'h21);
    wr(1'b1, 8'h00);
    meas(hi, lo);
    check_int("R2 resume high", hi, 3);
    check_int("R2 resume low", lo, 2);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule